// File: doc/BRIEF.md
# Serial Configuration Loader for a Receiver Front-End

This block brings up an external receiver front-end over a three-wire write-only link. The link has a serial clock, an active-low select and a data line. A single-cycle `start` pulse makes it send ten 32-bit frames, one for each configuration register, in a fixed order. It then pulses `done`. The register values come from a built-in table of power-on settings. One field, the 2-bit amplifier input selection in register 0, is taken from the `lna_mode` port instead.

Each frame sends the 28-bit value first, then the 4-bit register number. A bit goes out as a low half-period with the data set up, followed by a high half-period. After the last bit the select line goes high for one extra clock pulse and then drops for a short while. An idle gap of `GAP_CYCLES` system clocks, with the select line high, separates each frame from the next step. `DIV` sets the length of each serial-clock half-period in system clocks.

Top module: `serial_cfg_loader`

## Requirements
- R1: Each frame shifts 32 bits, MSB first: the 28-bit register value (bits 27..0), then the 4-bit register number (bits 3..0). The target captures `sdata` on the rising edge of `sclk`.
- R2: `sclk` is low for exactly `DIV` system clocks before each rising edge, and high for exactly `DIV` clocks. `sdata` changes only while `sclk` is low.
- R3: When a frame begins, `csn` falls while `sclk` is low. No `sclk` rising edge occurs before that.
- R4: After bit 32, `csn` goes high and one extra `sclk` pulse follows. `csn` therefore stays high for exactly 2·`DIV` clocks, then low for exactly `DIV` clocks.
- R5: After each latch, `csn` is high for exactly `GAP_CYCLES` clocks before the next frame begins or `done` is given.
- R6: Registers are sent in number order 0 to 9. Their values are 0xA2919A3, 0x055028C, 0xEAFE1DC, 0x9EC0008, 0x0C00080, 0x8000070, 0x8000000, 0x10061B2, 0x1E0F401 and 0x28C0402.
- R7: In register 0, bits 14:13 are replaced by the value `lna_mode` holds in the cycle of `start`. Later changes to `lna_mode` have no effect. With value 1, the word sent is 0xA2939A3.
- R8: A `start` pulse that arrives while `busy` is high is ignored. Exactly ten frames and one `done` are produced.
- R9: `busy` rises in the cycle after `start`. `done` is high for one cycle, exactly `GAP_CYCLES` clocks after `csn` rises for the last gap, and `busy` is low in that cycle.
- R10: A synchronous active-high `rst` forces `sclk`=0, `csn`=1, `sdata`=0, `busy`=0 and `done`=0 in the next cycle. Reset works from any point in a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to send all ten registers |
| lna_mode | input | 2 | Value placed in bits 14:13 of register 0 |
| sclk | output | 1 | Serial clock to the target |
| csn | output | 1 | Active-low select |
| sdata | output | 1 | Serial data |
| busy | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
All outputs decode directly from the state register. A result therefore appears in the cycle after the edge that moves the state: `busy` in the cycle after `start`, and each `sclk` or `csn` edge exactly `DIV` clocks after the one before. The bench samples on the falling system-clock edge and measures run lengths of `sclk` and `csn` in whole cycles. It compares those lengths with exact values: `DIV` for half-periods, 2·`DIV` and `DIV` around the latch, and `GAP_CYCLES` for gaps and for the delay before `done`. It sweeps all four values of the override field. In one sweep it changes `lna_mode` right after `start`, and in another it sends a second `start` while busy.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int DIV        = 4,
  parameter int GAP_CYCLES = 125000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] lna_mode,
  output logic       sclk,
  output logic       csn,
  output logic       sdata,
  output logic       busy,
  output logic       done
);
  localparam int CMAX = (GAP_CYCLES > DIV) ? GAP_CYCLES : DIV;
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYCLES - 1);
  localparam logic [3:0] LAST_REG = 4'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_LAT_LO, S_LAT_HI, S_LAT_END, S_GAP
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [4:0]    bitn;
  logic [3:0]    idx;
  logic [31:0]   sh;

  function automatic logic [31:0] frame_of(input logic [3:0] i, input logic [1:0] m);
    logic [27:0] w;
    case (i)
      4'd0: w = 28'hA2919A3;
      4'd1: w = 28'h055028C;
      4'd2: w = 28'hEAFE1DC;
      4'd3: w = 28'h9EC0008;
      4'd4: w = 28'h0C00080;
      4'd5: w = 28'h8000070;
      4'd6: w = 28'h8000000;
      4'd7: w = 28'h10061B2;
      4'd8: w = 28'h1E0F401;
      4'd9: w = 28'h28C0402;
      default: w = 28'h0;
    endcase
    if (i == 4'd0) w[14:13] = m;
    return {w, i};
  endfunction

  wire [CW-1:0] lim  = (st == S_GAP) ? GAP_LAST : DIV_LAST;
  wire          tick = (cnt == lim);

  assign sclk  = (st == S_HI) || (st == S_LAT_HI);
  assign csn   = !((st == S_LO) || (st == S_HI) || (st == S_LAT_END));
  assign sdata = ((st == S_LO) || (st == S_HI)) ? sh[31] : 1'b0;
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bitn <= '0;
      idx  <= '0;
      sh   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE) cnt <= tick ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          sh   <= frame_of(4'd0, lna_mode);
          idx  <= 4'd0;
          bitn <= '0;
          cnt  <= '0;
          st   <= S_LO;
        end
        S_LO: if (tick) st <= S_HI;
        S_HI: if (tick) begin
          sh   <= {sh[30:0], 1'b0};
          bitn <= bitn + 1'b1;
          st   <= (bitn == 5'd31) ? S_LAT_LO : S_LO;
        end
        S_LAT_LO:  if (tick) st <= S_LAT_HI;
        S_LAT_HI:  if (tick) st <= S_LAT_END;
        S_LAT_END: if (tick) st <= S_GAP;
        S_GAP: if (tick) begin
          if (idx == LAST_REG) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            idx  <= idx + 1'b1;
            sh   <= frame_of(idx + 1'b1, 2'b00);
            bitn <= '0;
            st   <= S_LO;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module serial_cfg_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] lna_mode,
  input logic       sclk,
  input logic       csn,
  input logic       sdata,
  input logic       busy,
  input logic       done
);
  // R2
  data_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (csn && !sclk && !sdata));
  // R3
  select_fall_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(csn) |-> !sclk);
  // R4
  select_rise_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(csn) |-> !sclk);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (.*);

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;
  localparam int DIV = 2;
  localparam int GAP = 20;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] lna = 2'b00;
  logic sclk, csn, sdata, busy, done;

  serial_cfg_loader #(.DIV(DIV), .GAP_CYCLES(GAP)) i_serial_cfg_loader (
    .clk(clk), .rst(rst), .start(start), .lna_mode(lna),
    .sclk(sclk), .csn(csn), .sdata(sdata), .busy(busy), .done(done));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int nb = 0, frames = 0, dones = 0, hirun = 0, lorun = 0, hicnt = 0, cslo = 0;
  logic [31:0] rx = '0;
  logic psclk = 1'b0, pcsn = 1'b1, latched = 1'b0;
  logic [1:0] seq_lna = 2'b00;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(input int i, input logic [1:0] m);
    logic [27:0] w;
    case (i)
      0: w = 28'hA2919A3;  1: w = 28'h055028C;  2: w = 28'hEAFE1DC;
      3: w = 28'h9EC0008;  4: w = 28'h0C00080;  5: w = 28'h8000070;
      6: w = 28'h8000000;  7: w = 28'h10061B2;  8: w = 28'h1E0F401;
      9: w = 28'h28C0402;  default: w = 28'h0;
    endcase
    if (i == 0) w = (w & ~28'h6000) | (28'(m) << 13);
    return {w, 4'(i)};
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst) begin
      nb = 0; rx = '0; hirun = 0; lorun = 0; hicnt = 0; cslo = 0; latched = 1'b0;
    end else begin
      if (done) begin
        dones++;
        chk(hicnt == GAP, "R9 done delay after last gap", hicnt, GAP);
        chk(frames == 10, "R6 frames before done", frames, 10);
      end
      if (sclk && !psclk) begin
        if (nb > 0) chk(lorun == DIV, "R2 sclk low time", lorun, DIV);
        if (!csn) begin
          rx = {rx[30:0], sdata};
          nb++;
        end else begin
          chk(nb == 32, "R4 bits before latch pulse", nb, 32);
          chk(rx == exp_frame(frames, seq_lna), "R1 R6 R7 frame content", rx, exp_frame(frames, seq_lna));
          frames++; nb = 0; latched = 1'b1;
        end
      end
      if (!sclk && psclk) chk(hirun == DIV, "R2 sclk high time", hirun, DIV);
      if (!csn && pcsn && busy) begin
        if (latched) begin
          chk(hicnt == 2*DIV, "R4 select high around latch", hicnt, 2*DIV);
          latched = 1'b0;
        end else begin
          chk(!sclk, "R3 sclk low at frame select", sclk, 0);
          chk(nb == 0, "R3 no clock before select", nb, 0);
          if (frames > 0) chk(hicnt == GAP, "R5 gap length", hicnt, GAP);
        end
      end
      if (csn && !pcsn && busy && nb == 0)
        chk(cslo == DIV, "R4 select low after latch", cslo, DIV);
      hirun = sclk ? (psclk ? hirun + 1 : 1) : 0;
      lorun = !sclk ? (!psclk ? lorun + 1 : 1) : 0;
      hicnt = (csn && busy) ? (pcsn ? hicnt + 1 : 1) : 0;
      cslo  = !csn ? (!pcsn ? cslo + 1 : 1) : 0;
    end
    psclk = sclk;
    pcsn  = csn;
  end

  task automatic idle_check(input string tag);
    chk(sclk == 1'b0, tag, sclk, 0);
    chk(csn == 1'b1, tag, csn, 1);
    chk(sdata == 1'b0, tag, sdata, 0);
    chk(busy == 1'b0, tag, busy, 0);
    chk(done == 1'b0, tag, done, 0);
  endtask

  task automatic run_seq(input logic [1:0] m, input bit inject);
    seq_lna = m; frames = 0; dones = 0;
    @(negedge clk); lna = m; start = 1'b1;
    @(negedge clk); start = 1'b0; lna = m ^ 2'b11;
    chk(busy, "R9 busy after start", busy, 1);
    if (inject) begin
      repeat (400) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int k = 0; k < 5000 && dones == 0; k++) @(negedge clk);
    repeat (200) @(negedge clk);
    chk(dones == 1, "R8 R9 exactly one done", dones, 1);
    chk(frames == 10, "R8 ten frames", frames, 10);
    chk(!busy, "R8 no restart from ignored start", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R10 reset state");
    rst = 1'b0;
    for (int m = 0; m < 4; m++) run_seq(2'(m), m == 2);
    seq_lna = 2'b01; frames = 0;
    @(negedge clk); lna = 2'b01; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    idle_check("R10 reset mid sequence");
    rst = 1'b0;
    run_seq(2'b01, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule